// File: doc/BRIEF.md
# Time-Triggered CAN Interrupt Flag Register

This block keeps three interrupt request flags for a time-triggered CAN controller and combines them into one interrupt line. One flag latches when a programmable 16-bit compare value equals the running cycle-time counter. A second flag marks the start of a new system matrix, raised when a time reference message completes under the right cycle-count configuration. The third flag reports mailbox overrun or overwrite as a summary of a per-mailbox unread-message vector that the block also keeps.

The CPU reads the flags and clears the first two by writing 1 to their bit positions. The summary flag ignores CPU writes. It falls only when every unread-message bit has been cleared (write 1 to the unread vector) or hidden by the mailbox mask. A per-flag enable selects which flags drive the combined interrupt output.

Top module: `ttcan_irq_flags`

## Requirements
- R1: The compare-match flag (flag bit 0) is 1 in the cycle after any clock edge at which `cmp_val_i` equals `cyc_time_i`.
- R2: Writing with `flg_wr_i` high and `flg_wdata_i` bit 0 (compare) or bit 1 (new matrix) at 1 clears that flag on the next edge. A 0 in that bit leaves the flag unchanged.
- R3: The new-matrix flag (flag bit 1) is set on an edge where `ref_done_i` is 1, `max_cyc_i` is not 3'b111 and `cyc_cnt_i` is zero.
- R4: With `max_cyc_i` = 0 every `ref_done_i` pulse sets the new-matrix flag, whatever `cyc_cnt_i` holds. With `max_cyc_i` = 3'b111 it is never set.
- R5: A message arrival (`arrive_i`) for mailbox `arrive_idx_i` sets that mailbox's bit of `unread_o` only if its `rx_pend_i` or `rfr_pend_i` bit is 1. Otherwise `unread_o` is unchanged.
- R6: A write with `unread_wr_i` clears every `unread_o` bit whose `unread_wdata_i` bit is 1 and leaves the others. A set and a clear of the same bit in one cycle leave it at 1.
- R7: The overrun flag (flag bit 2) is 1 exactly when some `unread_o` bit is 1 while the matching `mbx_mask_i` bit is 0.
- R8: A CPU flag write with bit 2 at 1 has no effect on the overrun flag.
- R9: When a set condition and a write-one-to-clear reach the compare or new-matrix flag in the same cycle, the flag is 1 afterwards.
- R10: `irq_o` is 1 exactly when some bit of `flags_o` and the same bit of `irq_en_i` are both 1.
- R11: After a cycle with `rst` high, `flags_o`, `unread_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_time_i | input | 16 | Running cycle-time counter value |
| cmp_val_i | input | 16 | Programmable compare value |
| ref_done_i | input | 1 | Time reference message sent or received successfully |
| max_cyc_i | input | 3 | Maximum cycle-count setting |
| cyc_cnt_i | input | 6 | Current basic-cycle count |
| arrive_i | input | 1 | Message arrival strobe |
| arrive_idx_i | input | 5 | Mailbox number of the arrival |
| rx_pend_i | input | 32 | Per-mailbox receive-pending bits |
| rfr_pend_i | input | 32 | Per-mailbox remote-request-pending bits |
| mbx_mask_i | input | 32 | Per-mailbox interrupt mask, 1 hides the mailbox |
| unread_wr_i | input | 1 | Write strobe for the unread vector |
| unread_wdata_i | input | 32 | Write-one-to-clear data for the unread vector |
| flg_wr_i | input | 1 | Write strobe for the flag register |
| flg_wdata_i | input | 3 | Flag write data, bit 0 compare, bit 1 new matrix, bit 2 overrun (ignored) |
| irq_en_i | input | 3 | Per-flag interrupt enable, same bit order as the flags |
| flags_o | output | 3 | Flag register read value |
| unread_o | output | 32 | Unread-message status vector |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check the local cause and effect. A compare hit or an accepted reference message must leave its flag at 1. A write-one-to-clear with no competing set must drop a flag. An arrival on a pending mailbox must mark its unread bit, and an arrival on a mailbox with nothing pending must leave that bit alone. The masked summary of the overrun flag, the cases where a write has no effect, and the full grid of maximum-cycle settings against cycle counts need values that live outside one edge. The bench shows those by sweeping every mailbox with every pending combination, every mask pattern in a sequence of clears, and every enable pattern.

// File: rtl/ttcan_irq_pkg.sv
package ttcan_irq_pkg;

    // Bit positions of the flags in the CPU-visible register.
    localparam int FLG_CMP  = 0;
    localparam int FLG_MTX  = 1;
    localparam int FLG_OVR  = 2;
    localparam int FLG_N    = 3;

    // Value of the maximum-cycle setting that disables new-matrix detection.
    localparam logic [2:0] MAXC_OFF  = 3'b111;
    localparam logic [2:0] MAXC_ZERO = 3'b000;

    typedef struct packed {
        logic ovr;
        logic mtx;
        logic cmp;
    } irq_flags_t;

    // Decide whether a completed reference message opens a new system matrix.
    function automatic logic matrix_opens(input logic [2:0] maxc,
                                          input logic       cnt_is_zero);
        logic enabled;
        enabled = (maxc != MAXC_OFF);
        return enabled && ((maxc == MAXC_ZERO) || cnt_is_zero);
    endfunction

endpackage

// File: rtl/ttcan_w1c_flag.sv
module ttcan_w1c_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    logic q_r;

    // A set event outranks a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)        q_r <= 1'b0;
        else if (set_i) q_r <= 1'b1;
        else if (clr_i) q_r <= 1'b0;
    end

    assign q_o = q_r;

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_i && clr_i) |=> q_o);                                  // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);                                // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(q_o));                       // R2

endmodule

// File: rtl/ttcan_event_detect.sv
module ttcan_event_detect
    import ttcan_irq_pkg::*;
#(
    parameter int CT_W  = 16,
    parameter int CNT_W = 6
) (
    input  logic [CT_W-1:0]  cyc_time_i,
    input  logic [CT_W-1:0]  cmp_val_i,
    input  logic             ref_done_i,
    input  logic [2:0]       max_cyc_i,
    input  logic [CNT_W-1:0] cyc_cnt_i,
    output logic             cmp_hit_o,
    output logic             mtx_hit_o
);

    logic cnt_zero;

    always_comb begin
        cnt_zero  = (cyc_cnt_i == '0);
        cmp_hit_o = (cyc_time_i == cmp_val_i);
        mtx_hit_o = ref_done_i && matrix_opens(max_cyc_i, cnt_zero);
    end

endmodule

// File: rtl/ttcan_unread_tracker.sv
module ttcan_unread_tracker #(
    parameter int NMBX  = 32,
    parameter int MBX_W = (NMBX > 1) ? $clog2(NMBX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arrive_i,
    input  logic [MBX_W-1:0] arrive_idx_i,
    input  logic [NMBX-1:0]  rx_pend_i,
    input  logic [NMBX-1:0]  rfr_pend_i,
    input  logic [NMBX-1:0]  mask_i,
    input  logic             wr_i,
    input  logic [NMBX-1:0]  wdata_i,
    output logic [NMBX-1:0]  unread_o,
    output logic             ovr_o
);

    logic [NMBX-1:0] ums_q;
    logic [NMBX-1:0] hit_v;
    logic [NMBX-1:0] busy_v;

    assign busy_v = rx_pend_i | rfr_pend_i;

    for (genvar i = 0; i < NMBX; i++) begin : g_mbx
        logic sel;
        logic clr;
        assign sel      = arrive_i && (arrive_idx_i == MBX_W'(i));
        assign hit_v[i] = sel && busy_v[i];
        assign clr      = wr_i && wdata_i[i];

        always_ff @(posedge clk) begin
            if (rst)           ums_q[i] <= 1'b0;
            else if (hit_v[i]) ums_q[i] <= 1'b1;
            else if (clr)      ums_q[i] <= 1'b0;
        end
    end

    assign unread_o = ums_q;
    assign ovr_o    = |(ums_q & ~mask_i);

    AST_UMS_MARK: assert property (@(posedge clk) disable iff (rst)
        (arrive_i && busy_v[arrive_idx_i]) |=> unread_o[$past(arrive_idx_i)]);  // R5
    AST_UMS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (arrive_i && !busy_v[arrive_idx_i] && !wr_i)
            |=> $stable(unread_o));                                             // R5
    AST_UMS_WIPE: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !arrive_i) |=> ((unread_o & $past(wdata_i)) == '0));           // R6

endmodule

// File: rtl/ttcan_irq_flags.sv
module ttcan_irq_flags
    import ttcan_irq_pkg::*;
#(
    parameter int NMBX  = 32,
    parameter int CT_W  = 16,
    parameter int CNT_W = 6,
    localparam int MBX_W = (NMBX > 1) ? $clog2(NMBX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CT_W-1:0]   cyc_time_i,
    input  logic [CT_W-1:0]   cmp_val_i,
    input  logic              ref_done_i,
    input  logic [2:0]        max_cyc_i,
    input  logic [CNT_W-1:0]  cyc_cnt_i,
    input  logic              arrive_i,
    input  logic [MBX_W-1:0]  arrive_idx_i,
    input  logic [NMBX-1:0]   rx_pend_i,
    input  logic [NMBX-1:0]   rfr_pend_i,
    input  logic [NMBX-1:0]   mbx_mask_i,
    input  logic              unread_wr_i,
    input  logic [NMBX-1:0]   unread_wdata_i,
    input  logic              flg_wr_i,
    input  logic [FLG_N-1:0]  flg_wdata_i,
    input  logic [FLG_N-1:0]  irq_en_i,
    output logic [FLG_N-1:0]  flags_o,
    output logic [NMBX-1:0]   unread_o,
    output logic              irq_o
);

    irq_flags_t flg;
    logic       cmp_hit;
    logic       mtx_hit;
    logic       clr_cmp;
    logic       clr_mtx;

    ttcan_event_detect #(
        .CT_W  (CT_W),
        .CNT_W (CNT_W)
    ) u_detect (
        .cyc_time_i (cyc_time_i),
        .cmp_val_i  (cmp_val_i),
        .ref_done_i (ref_done_i),
        .max_cyc_i  (max_cyc_i),
        .cyc_cnt_i  (cyc_cnt_i),
        .cmp_hit_o  (cmp_hit),
        .mtx_hit_o  (mtx_hit)
    );

    assign clr_cmp = flg_wr_i && flg_wdata_i[FLG_CMP];
    assign clr_mtx = flg_wr_i && flg_wdata_i[FLG_MTX];

    ttcan_w1c_flag u_cmp_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (cmp_hit),
        .clr_i (clr_cmp),
        .q_o   (flg.cmp)
    );

    ttcan_w1c_flag u_mtx_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (mtx_hit),
        .clr_i (clr_mtx),
        .q_o   (flg.mtx)
    );

    // Overrun summary: bit 2 of the CPU write data has no path into it.
    ttcan_unread_tracker #(
        .NMBX  (NMBX),
        .MBX_W (MBX_W)
    ) u_unread (
        .clk          (clk),
        .rst          (rst),
        .arrive_i     (arrive_i),
        .arrive_idx_i (arrive_idx_i),
        .rx_pend_i    (rx_pend_i),
        .rfr_pend_i   (rfr_pend_i),
        .mask_i       (mbx_mask_i),
        .wr_i         (unread_wr_i),
        .wdata_i      (unread_wdata_i),
        .unread_o     (unread_o),
        .ovr_o        (flg.ovr)
    );

    assign flags_o = flg;
    assign irq_o   = |(flags_o & irq_en_i);

    AST_CMP_LATCH: assert property (@(posedge clk) disable iff (rst)
        (cmp_val_i == cyc_time_i) |=> flags_o[FLG_CMP]);                     // R1
    AST_MTX_OPEN: assert property (@(posedge clk) disable iff (rst)
        (ref_done_i && max_cyc_i != MAXC_OFF && cyc_cnt_i == '0)
            |=> flags_o[FLG_MTX]);                                            // R3
    AST_MTX_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (max_cyc_i == MAXC_OFF && !flags_o[FLG_MTX]) |=> !flags_o[FLG_MTX]);  // R4
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (flags_o == '0) |-> !irq_o);                                          // R10

endmodule

// File: tb/ttcan_irq_flags_tb.sv
`timescale 1ns/1ps
module ttcan_irq_flags_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cyc_time, cmp_val;
    logic        ref_done;
    logic [2:0]  max_cyc;
    logic [5:0]  cyc_cnt;
    logic        arrive;
    logic [4:0]  arrive_idx;
    logic [31:0] rx_pend, rfr_pend, mask;
    logic        uwr;
    logic [31:0] uwdata;
    logic        fwr;
    logic [2:0]  fwdata, irq_en;
    logic [2:0]  flags;
    logic [31:0] unread;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] exp_ums;

    always #2.5 clk = ~clk;

    ttcan_irq_flags u_dut (
        .clk(clk), .rst(rst), .cyc_time_i(cyc_time), .cmp_val_i(cmp_val),
        .ref_done_i(ref_done), .max_cyc_i(max_cyc), .cyc_cnt_i(cyc_cnt),
        .arrive_i(arrive), .arrive_idx_i(arrive_idx), .rx_pend_i(rx_pend),
        .rfr_pend_i(rfr_pend), .mbx_mask_i(mask), .unread_wr_i(uwr),
        .unread_wdata_i(uwdata), .flg_wr_i(fwr), .flg_wdata_i(fwdata),
        .irq_en_i(irq_en), .flags_o(flags), .unread_o(unread), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cyc_time = 16'h0000; cmp_val = 16'hFFFF; ref_done = 1'b0;
        arrive = 1'b0; uwr = 1'b0; fwr = 1'b0; fwdata = '0; uwdata = '0;
    endtask

    task automatic wipe_flags();
        fwr = 1'b1; fwdata = 3'b011;
        step();
        fwr = 1'b0; fwdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1; max_cyc = 3'd7; cyc_cnt = 6'd1; arrive_idx = '0;
        rx_pend = '0; rfr_pend = '0; mask = '0; irq_en = 3'b111;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        // R11: reset state
        chk("R11 flags", 32'(flags), 32'd0);
        chk("R11 unread", unread, 32'd0);
        chk("R11 irq", 32'(irq), 32'd0);

        // R1 / R2: compare sweep, clear after each pair
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                cyc_time = 16'(a * 4097); cmp_val = 16'(b * 4097);
                step();
                chk("R1 compare", 32'(flags[0]), 32'(a == b));
                idle();
                wipe_flags();
                chk("R2 clear", 32'(flags[0]), 32'd0);
            end
        end
        // R2: writing 0 holds; R9: set beats clear
        cyc_time = 16'h1234; cmp_val = 16'h1234; step(); idle();
        fwr = 1'b1; fwdata = 3'b100; step(); fwr = 1'b0;
        chk("R2 write zero holds", 32'(flags[0]), 32'd1);
        cyc_time = 16'h55AA; cmp_val = 16'h55AA; fwr = 1'b1; fwdata = 3'b001;
        step(); idle();
        chk("R9 set wins cmp", 32'(flags[0]), 32'd1);
        wipe_flags();

        // R3 / R4: maximum-cycle setting against cycle count
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 4; c++) begin
                max_cyc = 3'(m); cyc_cnt = 6'(c);
                step();
                chk("R3 no ref no set", 32'(flags[1]), 32'd0);
                ref_done = 1'b1; step(); ref_done = 1'b0;
                chk((m == 0 || m == 7) ? "R4 matrix" : "R3 matrix", 32'(flags[1]),
                    32'((m != 7) && (m == 0 || c == 0)));
                wipe_flags();
                chk("R2 matrix clear", 32'(flags[1]), 32'd0);
            end
        end
        max_cyc = 3'd1; cyc_cnt = 6'd0; ref_done = 1'b1; fwr = 1'b1; fwdata = 3'b010;
        step(); idle();
        chk("R9 set wins mtx", 32'(flags[1]), 32'd1);
        wipe_flags();
        max_cyc = 3'd7;

        // R5 / R7: every mailbox with every pending combination, mask open
        exp_ums = '0;
        for (int mb = 0; mb < 32; mb++) begin
            for (int p = 0; p < 4; p++) begin
                rx_pend = 32'(p & 1) << mb; rfr_pend = 32'((p >> 1) & 1) << mb;
                arrive = 1'b1; arrive_idx = 5'(mb);
                step(); arrive = 1'b0;
                if (p != 0) exp_ums = exp_ums | (32'd1 << mb);
                chk("R5 unread mark", unread, exp_ums);
                chk("R7 overrun", 32'(flags[2]), 32'(exp_ums != 0));
            end
        end
        rx_pend = '0; rfr_pend = '0;
        // R7: mask sweep over an all-set vector
        for (int k = 0; k < 33; k++) begin
            mask = (k == 32) ? 32'hFFFF_FFFF : ~(32'd1 << k);
            @(negedge clk);
            chk("R7 mask", 32'(flags[2]), 32'(k != 32));
        end
        // R8: flag write bit 2 ignored
        mask = '0; fwr = 1'b1; fwdata = 3'b100; step(); fwr = 1'b0;
        chk("R8 overrun ignores write", 32'(flags[2]), 32'd1);
        // R6 / R7: clear bits one by one with upper half unmasked
        mask = 32'h0000_FFFF;
        for (int k = 31; k >= 0; k--) begin
            uwr = 1'b1; uwdata = 32'd1 << k; step(); uwr = 1'b0;
            exp_ums = exp_ums & ~(32'd1 << k);
            chk("R6 unread clear", unread, exp_ums);
            chk("R7 masked summary", 32'(flags[2]), 32'((exp_ums & ~mask) != 0));
        end
        // R6: set beats clear, zero writes hold
        mask = '0; rx_pend = 32'd1 << 5; arrive = 1'b1; arrive_idx = 5'd5;
        uwr = 1'b1; uwdata = 32'd1 << 5; step(); idle();
        chk("R6 set wins unread", unread, 32'h0000_0020);
        uwr = 1'b1; uwdata = 32'h0000_0000; step(); uwr = 1'b0;
        chk("R6 zero write holds", unread, 32'h0000_0020);
        rx_pend = '0; arrive = 1'b1; arrive_idx = 5'd9; step(); arrive = 1'b0;
        chk("R5 no pending no mark", unread, 32'h0000_0020);

        // R10: enable sweep with overrun only, then all flags
        for (int e = 0; e < 8; e++) begin
            irq_en = 3'(e); @(negedge clk);
            chk("R10 irq ovr only", 32'(irq), 32'((e >> 2) & 1));
        end
        cyc_time = 16'h0777; cmp_val = 16'h0777; max_cyc = 3'd0; ref_done = 1'b1;
        step(); idle();
        for (int e = 0; e < 8; e++) begin
            irq_en = 3'(e); @(negedge clk);
            chk("R10 irq all", 32'(irq), 32'(e != 0));
        end
        // R11: reset mid-run
        rst = 1'b1; step(); rst = 1'b0;
        chk("R11 reset flags", 32'(flags), 32'd0);
        chk("R11 reset unread", unread, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule